// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets an external controller read and write a bank of sixteen 8-bit configuration registers. The controller pulls the select line low to open a frame. It clocks in a command nibble, then an address nibble, then a data byte, all most-significant bit first. It raises select to close the frame. The block decodes the frame only at that closing edge, and only when exactly sixteen bits arrived. This means a truncated or overrun transfer cannot corrupt the configuration.

A read is a command of its own. The addressed register is captured when the next frame opens, and it is shifted out on a dedicated output during that next frame. The output enable is raised only for that frame. That next frame is itself decoded normally, so reads and writes can be chained back to back. All register contents are presented in parallel to the rest of the chip. Register 3 holds the oscillator divider that derives the 100 kHz reference, and it is also brought out on a port of its own.

The serial inputs are oversampled by a faster system clock. Edges of the serial clock and the select line are detected after a synchronizer.

Top module: `sreg_port`

## Requirements
- R1: After reset every register reads 0x00, except register 3, which reads OSC_DIV_RST (default 0x88). sdo_oe_o is low. Reset also cancels any pending read.
- R2: While cs_ni is low, sdi_i is sampled on each rising sclk_i edge. The first 4 bits are the command, the next 4 are the address and the last 8 are the data, each field MSB first.
- R3: A frame with exactly 16 bits and command 0x1 writes its data byte to the addressed register when cs_ni rises. No other register changes.
- R4: A frame that carries fewer or more than 16 bits changes no register and arms no read.
- R5: Command codes other than 0x1 (write) and 0x2 (read) change no register.
- R6: After a 16-bit frame with command 0x2, the next frame drives sdo_oe_o high and shifts the addressed register out on sdo_o, MSB first. D7 is valid from the falling edge of cs_ni, and each falling sclk_i edge advances one bit.
- R7: sdo_oe_o is low while cs_ni is high. It is also low during any frame that does not follow a valid read command, including the read command frame itself.
- R8: The returned byte is the register value when the return frame opens, even if that frame writes the same register.
- R9: osc_div_o always equals the content of register 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the controller, idle low |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial read data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high-impedance |
| regs_o | output | 128 | All registers, register n at bits 8n+7..8n |
| osc_div_o | output | 8 | Oscillator divider, a copy of register 3 |

## Verification
The bench sends 15-bit, 17-bit and empty frames. A design that committed on a partial count, or that let the shift register wrap, would overwrite a register with shifted garbage. Unused command codes 0x0, 0x3 and 0xF are sent with live addresses and data, to catch a decoder that writes on any nonzero code.

Read-back is checked for both timing edges. The output enable must stay low during the read command frame and again in the frame after the return. A design that enabled the output one frame early, or left it on, would be caught. One return frame writes the register it is reading, so a design that captured the data too late would return the new value. A reset issued between a read command and its return frame must suppress the return.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int CMD_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int FRAME_W  = CMD_W + ADDR_W + DATA_W;

  localparam logic [CMD_W-1:0] OP_WRITE = 4'h1;
  localparam logic [CMD_W-1:0] OP_READ  = 4'h2;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign q_o    = stg[STAGES-1];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cs_low_i,
  input  logic   start_i,
  input  logic   end_i,
  input  logic   sclk_rise_i,
  input  logic   sdi_i,
  output logic   done_o,
  output logic   valid_o,
  output frame_t frame_o
);
  localparam int CNT_MAX = FRAME_W + 1;  // saturates: marks an overlong frame
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (sclk_rise_i && cs_low_i) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o  = end_i;
  assign valid_o = (cnt_q == CNT_W'(FRAME_W));
  assign frame_o = frame_t'(shreg_q);

  a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX));

  a_r2_bit_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise_i && cs_low_i && !start_i) |=> shreg_q[0] == $past(sdi_i));
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int                OSC_ADDR = 3,
  parameter logic [DATA_W-1:0] OSC_RST  = 8'h88
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = (g == OSC_ADDR) ? OSC_RST : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         mem[g] <= RST_V;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g)) mem[g] <= wr_data_i;
    end

    assign regs_o[g*DATA_W +: DATA_W] = mem[g];

    a_r3_hold_unaddressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == ADDR_W'(g)) |=> $stable(mem[g]));
  end

  assign rd_data_o = mem[rd_addr_i];

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/sreg_sdo.sv
module sreg_sdo
  import sreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_low_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              sclk_fall_i,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic              pend_q, active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      active_q <= 1'b0;
      addr_q   <= '0;
      sr_q     <= '0;
    end else if (end_i) begin
      // every closed frame re-decides whether the next one returns data
      pend_q   <= arm_i;
      active_q <= 1'b0;
      if (arm_i) addr_q <= arm_addr_i;
    end else if (start_i) begin
      pend_q   <= 1'b0;
      active_q <= pend_q;
      if (pend_q) sr_q <= rd_data_i;  // snapshot at frame open
    end else if (active_q && sclk_fall_i && cs_low_i) begin
      sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign rd_addr_o = addr_q;
  assign sdo_o     = active_q & sr_q[DATA_W-1];
  assign sdo_oe_o  = active_q;

  a_r6_load_from_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(pend_q) && $past(start_i));

  a_r7_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_low_i && !end_i) |-> !active_q);
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter logic [7:0] OSC_DIV_RST = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         cs_ni,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic [127:0] regs_o,
  output logic [7:0]   osc_div_o
);
  localparam int OSC_ADDR = 3;
  localparam int IDX_CS = 2, IDX_SCLK = 1, IDX_SDI = 0;

  logic [2:0] q, rise, fall;
  logic cs_low, start, stop, done, valid, wr_en, arm;
  frame_t frame;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sclk_i, sdi_i}),
    .q_o(q), .rise_o(rise), .fall_o(fall)
  );

  assign cs_low = ~q[IDX_CS];
  assign start  = fall[IDX_CS];
  assign stop   = rise[IDX_CS];

  sreg_frame u_frame (
    .clk_i, .rst_ni, .cs_low_i(cs_low), .start_i(start), .end_i(stop),
    .sclk_rise_i(rise[IDX_SCLK]), .sdi_i(q[IDX_SDI]),
    .done_o(done), .valid_o(valid), .frame_o(frame)
  );

  assign wr_en = done && valid && frame.cmd == OP_WRITE;
  assign arm   = done && valid && frame.cmd == OP_READ;

  sreg_bank #(.OSC_ADDR(OSC_ADDR), .OSC_RST(OSC_DIV_RST)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(frame.addr),
    .wr_data_i(frame.data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .regs_o
  );

  sreg_sdo u_sdo (
    .clk_i, .rst_ni, .cs_low_i(cs_low), .start_i(start), .end_i(stop),
    .sclk_fall_i(fall[IDX_SCLK]), .arm_i(arm), .arm_addr_i(frame.addr),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .sdo_o, .sdo_oe_o
  );

  assign osc_div_o = regs_o[OSC_ADDR*DATA_W +: DATA_W];

  a_r9_osc_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && frame.addr == ADDR_W'(OSC_ADDR) |=> osc_div_o == $past(frame.data));
endmodule

// File: tb/tb_sreg_port.sv
module tb_sreg_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 40;
  localparam int NVEC  = 11;
  // {bit count, cmd, addr, data}
  localparam logic [23:0] VECS [NVEC] = '{
    {8'd16, 16'h105A}, {8'd16, 16'h1FC3}, {8'd16, 16'h1312},
    {8'd15, 16'h11FF}, {8'd17, 16'h12EE}, {8'd16, 16'h0477},
    {8'd16, 16'hF566}, {8'd16, 16'h3655}, {8'd16, 16'h1781},
    {8'd16, 16'h10A5}, {8'd0,  16'h1B99}
  };

  logic clk_i = 0, rst_ni = 0, sclk_i = 0, cs_ni = 1, sdi_i = 0;
  logic sdo_o, sdo_oe_o;
  logic [127:0] regs_o;
  logic [7:0] osc_div_o;
  int checks = 0, failures = 0;
  logic [7:0] model [16];

  sreg_port dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [127:0] packed_model();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    model[3] = 8'h88;
  endtask

  task automatic send(input logic [15:0] f, input int n,
                      output logic [7:0] rd, output bit oe_seen);
    rd = '0; oe_seen = 0;
    cs_ni = 0;
    #(2*HALF);
    for (int i = 0; i < n; i++) begin
      sdi_i = (i < 16) ? f[15-i] : 1'b0;
      #HALF;
      if (sdo_oe_o) oe_seen = 1;
      if (i < 8) rd[7-i] = sdo_o;
      sclk_i = 1;
      #HALF;
      sclk_i = 0;
    end
    #(2*HALF);
    cs_ni = 1;
    #(4*HALF);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    #(3*CLK_P);
    rst_ni = 1;
    #(3*CLK_P);
    model_reset();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P*200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    bit oe;
    #2;
    do_reset();
    // R1 reset state
    chk("R1 reset regs", regs_o, packed_model());
    chk("R1 reset oe", {127'd0, sdo_oe_o}, 128'd0);
    chk("R9 reset osc", {120'd0, osc_div_o}, {120'd0, 8'h88});

    // R2 R3 R4 R5: vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  nb;
      logic [15:0] f;
      nb = VECS[v][23:16];
      f  = VECS[v][15:0];
      send(f, int'(nb), rd, oe);
      if (nb == 8'd16 && f[15:12] == 4'h1) model[f[11:8]] = f[7:0];
      chk("R2/R3/R4/R5 regs after frame", regs_o, packed_model());
      chk("R7 no oe without read", {127'd0, oe}, 128'd0);
    end
    chk("R9 osc mirror", {120'd0, osc_div_o}, {120'd0, model[3]});

    // R6 read of register 15, returned in the next frame
    send(16'h2F00, 16, rd, oe);
    chk("R7 oe low in read command frame", {127'd0, oe}, 128'd0);
    send(16'h0000, 16, rd, oe);
    chk("R6 read data reg15", {120'd0, rd}, {120'd0, model[15]});
    chk("R6 oe during return", {127'd0, oe}, 128'd1);
    chk("R7 oe low after frame", {127'd0, sdo_oe_o}, 128'd0);
    send(16'h0000, 16, rd, oe);
    chk("R7 oe low in frame after return", {127'd0, oe}, 128'd0);

    // R6 chained reads: the return frame carries the next read
    send(16'h2300, 16, rd, oe);
    send(16'h2700, 16, rd, oe);
    chk("R6 chained read reg3", {120'd0, rd}, {120'd0, model[3]});
    send(16'h0000, 16, rd, oe);
    chk("R6 chained read reg7", {120'd0, rd}, {120'd0, model[7]});

    // R8 return frame overwrites the register being read
    send(16'h2000, 16, rd, oe);
    send(16'h103C, 16, rd, oe);
    chk("R8 old value returned", {120'd0, rd}, {120'd0, 8'hA5});
    model[0] = 8'h3C;
    chk("R8 write still applied", regs_o, packed_model());

    // R4 short read command arms nothing
    send(16'h2F00, 15, rd, oe);
    send(16'h0000, 16, rd, oe);
    chk("R4 short read no return", {127'd0, oe}, 128'd0);

    // R1 reset cancels a pending read and restores registers
    send(16'h2A00, 16, rd, oe);
    do_reset();
    chk("R1 reset restores regs", regs_o, packed_model());
    send(16'h0000, 16, rd, oe);
    chk("R1 reset cancels pending read", {127'd0, oe}, 128'd0);

    finish_run();
  end
endmodule